// File: doc/BRIEF.md
# Serial Memory Write-Protect Controller

This block keeps the protection state of a serial nonvolatile memory: a write-enable latch, a two-bit block-protect field and a pin-enable bit. The command decoder sends it strobes for enable and disable, status writes and command completion. For each array write attempt it returns a grant. For each status write attempt it also returns a grant. It always presents the current status byte.

The array is guarded only by the write-enable latch and the block-protect field. The active-low hardware protect pin has no effect on the array. It guards the status register, and only while the pin-enable bit is set. If both block-protect bits are 1, the pin-enable bit is 1 and the pin is held low, no sequence of commands can change any array location. Only the hardware pin can lift this lock.

Grants are combinational: they are valid in the same cycle as the request. A state change made by any strobe takes effect at the next rising clock edge.

Top module: `wp_guard`

## Requirements
- R1: A synchronous reset, while `rst` is high at a clock edge, clears all state. Both grants then read 0 and `status_o` reads 8'h00.
- R2: `en_set_i` sets the write-enable latch. `status_o[1]` reads 1 after the next clock edge.
- R3: `en_clr_i` or `cmd_done_i` clears the write-enable latch at the next edge. If either of them is high in the same cycle as `en_set_i`, the latch ends up cleared.
- R4: While the write-enable latch is 0, `arr_grant_o` and `stat_grant_o` are both 0, whatever the pin, the address and the other bits are.
- R5: A granted status write loads `stat_wdata_i[7]` into the pin-enable bit and `stat_wdata_i[3:2]` into the block-protect field at the next edge. The status byte reads {pin-enable, 3'b000, block-protect, latch, 1'b0}. Data bits 6:4, 1 and 0 have no effect, and the latch is not changed by a status write.
- R6: While the pin-enable bit is 1 and `wp_n_i` is 0, `stat_grant_o` is 0 even with the latch set. A refused status write leaves the status byte unchanged.
- R7: While the pin-enable bit is 0, `wp_n_i` has no effect on either grant.
- R8: `wp_n_i` never changes `arr_grant_o`.
- R9: The block-protect field selects the locked range of the 13-bit array address. 00 locks nothing. 01 locks 1800h–1FFFh. 10 locks 1000h–1FFFh. 11 locks the whole array. With the latch set, an address outside the locked range is granted and an address inside it is refused.
- R10: Bits 15:13 of `arr_addr_i` have no effect on the array grant.
- R11: A grant is 1 only in a cycle where its own request input is high.
- R12: With both block-protect bits at 1, pin-enable at 1 and `wp_n_i` low, both grants are 0 for every address.

Top module port order follows below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_set_i | input | 1 | Strobe: set the write-enable latch |
| en_clr_i | input | 1 | Strobe: clear the write-enable latch |
| cmd_done_i | input | 1 | Strobe: a write or status-write command has completed |
| stat_wr_i | input | 1 | Status write attempt |
| stat_wdata_i | input | 8 | Data for the status write |
| arr_wr_i | input | 1 | Array write attempt |
| arr_addr_i | input | 16 | Array address; the low 13 bits are used |
| wp_n_i | input | 1 | Hardware write-protect pin, active low |
| arr_grant_o | output | 1 | Array write is permitted |
| stat_grant_o | output | 1 | Status write is permitted |
| status_o | output | 8 | Current status byte |

## Verification
Both grants are combinational, so each is due in the same cycle as its request. The bench drives a request a short time after a rising edge and samples the grant before the next edge. Every change to the latch, the pin-enable bit or the block-protect field takes one register stage. The bench holds a strobe across exactly one rising edge and reads `status_o` in the cycle that follows. For the table-driven cases, the configuration is built up and confirmed through `status_o` first. The requests are then applied and both grants are read together.

// File: rtl/wp_pkg.sv
package wp_pkg;

    localparam int ARRAY_AW = 13;
    localparam int BUS_AW   = 16;
    localparam int STAT_W   = 8;

    localparam int SB_PINEN = 7;
    localparam int SB_BP_HI = 3;
    localparam int SB_BP_LO = 2;
    localparam int SB_LATCH = 1;

    typedef enum logic [1:0] {
        BP_NONE    = 2'b00,
        BP_QUARTER = 2'b01,
        BP_HALF    = 2'b10,
        BP_ALL     = 2'b11
    } bp_e;

    typedef struct packed {
        logic pin_en;
        bp_e  bp;
        logic latch;
    } prot_state_t;

    localparam prot_state_t PROT_RESET = '{pin_en: 1'b0, bp: BP_NONE, latch: 1'b0};

    function automatic logic [STAT_W-1:0] pack_status(input prot_state_t s);
        logic [STAT_W-1:0] b;
        b = '0;
        b[SB_PINEN]          = s.pin_en;
        b[SB_BP_HI:SB_BP_LO] = s.bp;
        b[SB_LATCH]          = s.latch;
        return b;
    endfunction

    function automatic logic pin_blocks_status(input prot_state_t s, input logic wp_n);
        return s.pin_en && !wp_n;
    endfunction

endpackage

// File: rtl/wp_status_reg.sv
module wp_status_reg
    import wp_pkg::*;
#(
    parameter int DATA_W = STAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_i,
    input  logic              clr_i,
    input  logic              done_i,
    input  logic              upd_i,
    input  logic [DATA_W-1:0] wdata_i,
    output prot_state_t       state_o
);

    prot_state_t cur_q, nxt;

    always_comb begin
        nxt = cur_q;
        if (upd_i) begin
            nxt.pin_en = wdata_i[SB_PINEN];
            nxt.bp     = bp_e'(wdata_i[SB_BP_HI:SB_BP_LO]);
        end
        // Clearing takes precedence over setting.
        if (clr_i || done_i)
            nxt.latch = 1'b0;
        else if (set_i)
            nxt.latch = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= PROT_RESET;
        else
            cur_q <= nxt;
    end

    logic unused_wdata;
    assign unused_wdata = ^{wdata_i[DATA_W-1:0]};

    assign state_o = cur_q;

endmodule

// File: rtl/wp_region_check.sv
module wp_region_check
    import wp_pkg::*;
#(
    parameter int AW   = ARRAY_AW,
    parameter int IN_W = BUS_AW
) (
    input  logic [IN_W-1:0] addr_i,
    input  bp_e             bp_i,
    output logic            locked_o
);

    localparam int TOP_HI = AW - 1;
    localparam int TOP_LO = AW - 2;

    logic [1:0] top2;

    generate
        if (IN_W > AW) begin : g_drop
            logic unused_hi;
            assign unused_hi = ^addr_i[IN_W-1:AW];
        end
    endgenerate

    assign top2 = addr_i[TOP_HI:TOP_LO];

    always_comb begin
        unique case (bp_i)
            BP_NONE:    locked_o = 1'b0;
            BP_QUARTER: locked_o = (top2 == 2'b11);
            BP_HALF:    locked_o = top2[1];
            BP_ALL:     locked_o = 1'b1;
            default:    locked_o = 1'b1;
        endcase
    end

    logic unused_low;
    assign unused_low = ^addr_i[TOP_LO-1:0];

endmodule

// File: rtl/wp_grant.sv
module wp_grant
    import wp_pkg::*;
(
    input  prot_state_t state_i,
    input  logic        wp_n_i,
    input  logic        arr_req_i,
    input  logic        stat_req_i,
    input  logic        region_locked_i,
    output logic        arr_ok_o,
    output logic        stat_ok_o
);

    always_comb begin
        arr_ok_o  = arr_req_i  && state_i.latch && !region_locked_i;
        stat_ok_o = stat_req_i && state_i.latch && !pin_blocks_status(state_i, wp_n_i);
    end

endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_pkg::*;
#(
    parameter int AW     = ARRAY_AW,
    parameter int IN_AW  = BUS_AW,
    parameter int DATA_W = STAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_set_i,
    input  logic              en_clr_i,
    input  logic              cmd_done_i,
    input  logic              stat_wr_i,
    input  logic [DATA_W-1:0] stat_wdata_i,
    input  logic              arr_wr_i,
    input  logic [IN_AW-1:0]  arr_addr_i,
    input  logic              wp_n_i,
    output logic              arr_grant_o,
    output logic              stat_grant_o,
    output logic [DATA_W-1:0] status_o
);

    prot_state_t st;
    logic        locked;
    logic        s_ok;

    wp_status_reg #(.DATA_W(DATA_W)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .set_i   (en_set_i),
        .clr_i   (en_clr_i),
        .done_i  (cmd_done_i),
        .upd_i   (s_ok),
        .wdata_i (stat_wdata_i),
        .state_o (st)
    );

    wp_region_check #(.AW(AW), .IN_W(IN_AW)) u_region (
        .addr_i   (arr_addr_i),
        .bp_i     (st.bp),
        .locked_o (locked)
    );

    wp_grant u_grant (
        .state_i         (st),
        .wp_n_i          (wp_n_i),
        .arr_req_i       (arr_wr_i),
        .stat_req_i      (stat_wr_i),
        .region_locked_i (locked),
        .arr_ok_o        (arr_grant_o),
        .stat_ok_o       (s_ok)
    );

    assign stat_grant_o = s_ok;
    assign status_o     = pack_status(st);

endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       en_set_i,
    input logic       en_clr_i,
    input logic       cmd_done_i,
    input logic       stat_wr_i,
    input logic       arr_wr_i,
    input logic       wp_n_i,
    input logic       arr_grant_o,
    input logic       stat_grant_o,
    input logic [7:0] status_o
);

    AST_LATCH_SET: assert property (@(posedge clk) disable iff (rst)
        (en_set_i && !en_clr_i && !cmd_done_i) |=> status_o[1]); // R2

    AST_LATCH_CLR: assert property (@(posedge clk) disable iff (rst)
        (en_clr_i || cmd_done_i) |=> !status_o[1]); // R3

    AST_NO_GRANT_WITHOUT_LATCH: assert property (@(posedge clk) disable iff (rst)
        (arr_grant_o || stat_grant_o) |-> status_o[1]); // R4

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (status_o[6:4] == 3'b000) && !status_o[0]); // R5

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !stat_grant_o |=> $stable({status_o[7], status_o[3:2]})); // R6

    AST_PIN_LOCK: assert property (@(posedge clk) disable iff (rst)
        (status_o[7] && !wp_n_i) |-> !stat_grant_o); // R6

    AST_ARR_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        arr_grant_o |-> arr_wr_i); // R11

    AST_STAT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        stat_grant_o |-> stat_wr_i); // R11

    AST_FULL_LOCK: assert property (@(posedge clk) disable iff (rst)
        (status_o[7] && status_o[3:2] == 2'b11 && !wp_n_i) |-> !(arr_grant_o || stat_grant_o)); // R12

endmodule

bind wp_guard wp_guard_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .en_set_i     (en_set_i),
    .en_clr_i     (en_clr_i),
    .cmd_done_i   (cmd_done_i),
    .stat_wr_i    (stat_wr_i),
    .arr_wr_i     (arr_wr_i),
    .wp_n_i       (wp_n_i),
    .arr_grant_o  (arr_grant_o),
    .stat_grant_o (stat_grant_o),
    .status_o     (status_o)
);

// File: tb/wp_guard_test.sv
module wp_guard_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        en_set_i, en_clr_i, cmd_done_i;
    logic        stat_wr_i;
    logic [7:0]  stat_wdata_i;
    logic        arr_wr_i;
    logic [15:0] arr_addr_i;
    logic        wp_n_i;
    logic        arr_grant_o, stat_grant_o;
    logic [7:0]  status_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    wp_guard uut (
        .clk(clk), .rst(rst), .en_set_i(en_set_i), .en_clr_i(en_clr_i),
        .cmd_done_i(cmd_done_i), .stat_wr_i(stat_wr_i), .stat_wdata_i(stat_wdata_i),
        .arr_wr_i(arr_wr_i), .arr_addr_i(arr_addr_i), .wp_n_i(wp_n_i),
        .arr_grant_o(arr_grant_o), .stat_grant_o(stat_grant_o), .status_o(status_o)
    );

    // {latch, pin_en, bp[1:0], wp_n, addr[15:0], exp_arr, exp_stat}
    localparam int NV = 13;
    localparam logic [22:0] VEC [NV] = '{
        {1'b0, 1'b0, 2'b00, 1'b1, 16'h0000, 1'b0, 1'b0},  // R4
        {1'b0, 1'b1, 2'b00, 1'b1, 16'h0000, 1'b0, 1'b0},  // R4
        {1'b1, 1'b0, 2'b00, 1'b0, 16'h1FFF, 1'b1, 1'b1},  // R7 R8
        {1'b1, 1'b1, 2'b00, 1'b0, 16'h0005, 1'b1, 1'b0},  // R6 R8
        {1'b1, 1'b1, 2'b00, 1'b1, 16'h0005, 1'b1, 1'b1},  // R6
        {1'b1, 1'b0, 2'b01, 1'b1, 16'h17FF, 1'b1, 1'b1},  // R9
        {1'b1, 1'b0, 2'b01, 1'b1, 16'h1800, 1'b0, 1'b1},  // R9
        {1'b1, 1'b0, 2'b10, 1'b1, 16'h0FFF, 1'b1, 1'b1},  // R9
        {1'b1, 1'b0, 2'b10, 1'b1, 16'h1000, 1'b0, 1'b1},  // R9
        {1'b1, 1'b0, 2'b11, 1'b1, 16'h0000, 1'b0, 1'b1},  // R9
        {1'b1, 1'b1, 2'b11, 1'b0, 16'h0000, 1'b0, 1'b0},  // R12
        {1'b1, 1'b0, 2'b01, 1'b1, 16'hE7FF, 1'b1, 1'b1},  // R10
        {1'b1, 1'b0, 2'b01, 1'b1, 16'hF800, 1'b0, 1'b1}   // R10
    };

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle();
        en_set_i = 0; en_clr_i = 0; cmd_done_i = 0;
        stat_wr_i = 0; arr_wr_i = 0;
    endtask

    task automatic pulse_set();
        en_set_i = 1; tick(); en_set_i = 0;
    endtask

    task automatic pulse_done();
        cmd_done_i = 1; tick(); cmd_done_i = 0;
    endtask

    task automatic stat_write(input logic [7:0] d);
        stat_wdata_i = d; stat_wr_i = 1; tick(); stat_wr_i = 0;
    endtask

    initial begin
        rst = 1; idle(); stat_wdata_i = 0; arr_addr_i = 0; wp_n_i = 1;
        repeat (3) tick();
        #1;
        check("R1 status", status_o, 8'h00);
        check("R1 grants", {6'b0, arr_grant_o, stat_grant_o}, 8'h00);
        rst = 0;
        tick();

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [7:0] cfg;
            logic [22:0] v;
            v = VEC[i];
            cfg = {v[21], 3'b000, v[20:19], 2'b00};
            wp_n_i = 1;
            pulse_set();
            stat_write(cfg);
            pulse_done();
            if (v[22]) pulse_set();
            #1;
            check($sformatf("R5 vec%0d status", i), status_o, cfg | {6'b0, v[22], 1'b0});
            wp_n_i = v[18]; arr_addr_i = v[17:2];
            arr_wr_i = 1; stat_wr_i = 1; stat_wdata_i = cfg;
            #1;
            check($sformatf("R9 vec%0d grants", i), {6'b0, arr_grant_o, stat_grant_o}, {6'b0, v[1], v[0]});
            tick();
            idle();
            pulse_done();
        end

        // R11: no request, no grant
        wp_n_i = 1; arr_addr_i = 0; pulse_set();
        stat_write(8'h00);
        #1;
        check("R11 grants idle", {6'b0, arr_grant_o, stat_grant_o}, 8'h00);
        check("R2 latch set", status_o, 8'h02);

        // R5: ignored data bits, latch unchanged
        stat_write(8'hFF);
        #1;
        check("R5 masked write", status_o, 8'h8E);
        stat_write(8'h72);
        #1;
        check("R5 ignored bits", status_o, 8'h02);
        stat_write(8'h88);

        // R6: refused write leaves state
        wp_n_i = 0;
        stat_write(8'h04);
        #1;
        check("R6 refused", status_o, 8'h8A);
        wp_n_i = 1;

        // R3: clear beats set
        en_set_i = 1; en_clr_i = 1; tick(); idle();
        #1;
        check("R3 clr over set", status_o, 8'h88);
        pulse_set();
        en_set_i = 1; cmd_done_i = 1; tick(); idle();
        #1;
        check("R3 done over set", status_o, 8'h88);
        pulse_set();
        en_clr_i = 1; tick(); idle();
        #1;
        check("R3 clr strobe", status_o, 8'h88);

        // R4: latch clear blocks everything
        arr_wr_i = 1; stat_wr_i = 1; arr_addr_i = 16'h0000; #1;
        check("R4 latch off", {6'b0, arr_grant_o, stat_grant_o}, 8'h00);
        idle();

        // R1: reset mid-run
        pulse_set();
        rst = 1; tick(); rst = 0;
        #1;
        check("R1 re-reset", status_o, 8'h00);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule